// File: doc/BRIEF.md
# Display Controller Boot Sequencer

This block brings an SPI-attached graphics controller out of reset without any help from software. Once system reset is released it runs a fixed script. It power-cycles the controller through an active-low power-down pin and sends four three-byte host commands, each with its own millisecond wait. It then reads an identification register until the controller answers with the expected value. After that it raises a select line that moves the serial clock to its fast rate and writes the display timing, the display-list start words, the list swap and finally the pixel clock.

The block does not serialise anything itself. Each bus access is handed to a separate transaction engine as one request: a kind (host command, read or write), an address, write data and a byte count. The request is held until the engine acknowledges it, and read data comes back with the acknowledge. Waits are measured with a millisecond tick taken from a parameterised divider of the system clock. The identification poll has a retry limit. A flag set reports a running sequence, a completed bring-up, or a controller that never identified itself.

Top module: `disp_boot_seq`

## Requirements
- R1: While reset is held and on the first cycle after it: pwr_dn_n=1, spi_fast=0, req_valid=0, done=0, err=0. busy is 1 from the first cycle after reset until done or err rises.
- R2: pwr_dn_n goes low first and stays low for 20 ms (20*CLKS_PER_MS cycles, plus at most six cycles of step overhead). It then goes high and stays high at least 20 ms before the first request. No request is ever presented while pwr_dn_n is low.
- R3: Four host command requests (req_kind=0, req_size=0, command byte in req_wdata[7:0]) are issued in this order: 0x00 followed by a 20 ms wait, 0x44 followed by 10 ms, 0x62 followed by 10 ms, and 0x68 with no wait. A wait is measured from the acknowledge to the next request.
- R4: A request (req_valid=1) keeps req_kind, req_size, req_addr and req_wdata unchanged until the cycle in which req_ack=1 is sampled. It is withdrawn in the following cycle.
- R5: After the host commands, single-byte reads (req_kind=1, req_size=0) of address 0x302040 are repeated until the byte returned on req_rdata with the acknowledge equals 0x7C.
- R6: spi_fast is 0 during every identification read and rises after the matching read and before the first write. It is 1 for every write.
- R7: After a match, 16-bit writes (req_kind=2, req_size=1) go to 0x302000+4*k for k=0..9 with values 548, 43, 480, 0, 41, 292, 12, 272, 0, 10 (horizontal cycle, offset, size, sync start, sync end, then the same five vertical). These are followed by 8-bit writes (req_size=0) of 0 to 0x302028, 1 to 0x30202C and 1 to 0x302030.
- R8: Next come 32-bit writes (req_size=2) of 0x26000007 to 0x300000 and 0x00000000 to 0x300004, then an 8-bit write of 1 to the swap register 0x302038. The last request is an 8-bit write of 5 to the pixel clock register 0x302034.
- R9: If MAX_POLLS reads in a row return a value other than 0x7C, err rises and stays set until reset, and busy and done are 0. No further request follows and spi_fast stays 0.
- R10: After the final write is acknowledged, done rises and stays set until reset, busy is 0, and no further request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the script restarts on release |
| req_ack | input | 1 | Transaction engine accepts the current request |
| req_rdata | input | 8 | Read byte, valid together with req_ack for a read |
| pwr_dn_n | output | 1 | Active-low power-down pin of the controller |
| spi_fast | output | 1 | Selects the fast serial clock divider |
| req_valid | output | 1 | A request is presented |
| req_kind | output | 2 | 0 host command, 1 read, 2 write |
| req_size | output | 2 | 0 one byte, 1 two bytes, 2 four bytes |
| req_addr | output | 24 | Target address of a read or write |
| req_wdata | output | 32 | Write data, or the command byte in bits 7:0 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Bring-up finished |
| err | output | 1 | Identification retry limit reached |

## Verification
The bench stalls the acknowledge for a random number of cycles and answers the identification reads with a varying number of wrong bytes. These include none, one short of the limit, and more than the limit. An off-by-one in the retry counter shows up as one read too many or too few, or as err raised on a run that should have succeeded. The bench times every wait against the millisecond divider, so a timer that drops a tick or keeps a free-running phase yields a short or jittered gap. It also checks the write order and the state of the fast clock select at each request, which catches a pixel clock written before the display list or a clock speed-up before identification.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int MS_W   = 5;
    localparam int STEP_W = 5;
    localparam int NUM_TIMING = 10;

    localparam logic [ADDR_W-1:0] REG_BASE = 24'h302000;
    localparam logic [ADDR_W-1:0] DL_BASE  = 24'h300000;
    localparam logic [ADDR_W-1:0] ID_ADDR  = 24'h302040;
    localparam logic [7:0]        ID_VALUE = 8'h7C;

    localparam logic [7:0] HC_WAKE    = 8'h00;
    localparam logic [7:0] HC_EXT_OSC = 8'h44;
    localparam logic [7:0] HC_PLL_48  = 8'h62;
    localparam logic [7:0] HC_CORE_RS = 8'h68;

    typedef enum logic [1:0] {
        REQ_HOST  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2
    } req_size_e;

    typedef enum logic [2:0] {
        OP_PDN_LOW,
        OP_PDN_HIGH,
        OP_HOST,
        OP_POLL,
        OP_FAST,
        OP_WRITE,
        OP_END
    } step_op_e;

    typedef struct packed {
        step_op_e          op;
        req_size_e         size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [MS_W-1:0]   ms;
    } step_t;

    function automatic logic [15:0] timing_val(input int k);
        case (k)
            0:       return 16'd548;
            1:       return 16'd43;
            2:       return 16'd480;
            3:       return 16'd0;
            4:       return 16'd41;
            5:       return 16'd292;
            6:       return 16'd12;
            7:       return 16'd272;
            8:       return 16'd0;
            default: return 16'd10;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] reg_addr(input int k);
        return REG_BASE + ADDR_W'(4 * k);
    endfunction

    function automatic step_t mk(input step_op_e op, input req_size_e sz,
                                 input logic [ADDR_W-1:0] a,
                                 input logic [DATA_W-1:0] d, input int ms);
        step_t s;
        s.op   = op;
        s.size = sz;
        s.addr = a;
        s.data = d;
        s.ms   = MS_W'(ms);
        return s;
    endfunction

    function automatic req_kind_e kind_of(input step_op_e op);
        case (op)
            OP_POLL:  return REQ_READ;
            OP_WRITE: return REQ_WRITE;
            default:  return REQ_HOST;
        endcase
    endfunction

    // Boot script: one entry per step, index advances in order.
    function automatic step_t boot_step(input logic [STEP_W-1:0] idx);
        int i;
        i = int'(idx);
        case (i)
            0:  return mk(OP_PDN_LOW,  SZ_B1, '0, '0, 20);
            1:  return mk(OP_PDN_HIGH, SZ_B1, '0, '0, 20);
            2:  return mk(OP_HOST, SZ_B1, '0, {24'h0, HC_WAKE},    20);
            3:  return mk(OP_HOST, SZ_B1, '0, {24'h0, HC_EXT_OSC}, 10);
            4:  return mk(OP_HOST, SZ_B1, '0, {24'h0, HC_PLL_48},  10);
            5:  return mk(OP_HOST, SZ_B1, '0, {24'h0, HC_CORE_RS}, 0);
            6:  return mk(OP_POLL, SZ_B1, ID_ADDR, {24'h0, ID_VALUE}, 0);
            7:  return mk(OP_FAST, SZ_B1, '0, '0, 0);
            18: return mk(OP_WRITE, SZ_B1, reg_addr(10), 32'd0, 0);
            19: return mk(OP_WRITE, SZ_B1, reg_addr(11), 32'd1, 0);
            20: return mk(OP_WRITE, SZ_B1, reg_addr(12), 32'd1, 0);
            21: return mk(OP_WRITE, SZ_B4, DL_BASE, 32'h2600_0007, 0);
            22: return mk(OP_WRITE, SZ_B4, DL_BASE + 24'd4, 32'h0, 0);
            23: return mk(OP_WRITE, SZ_B1, reg_addr(14), 32'd1, 0);
            24: return mk(OP_WRITE, SZ_B1, reg_addr(13), 32'd5, 0);
            default: begin
                if (i >= 8 && i < 8 + NUM_TIMING)
                    return mk(OP_WRITE, SZ_B2, reg_addr(i - 8),
                              {16'h0, timing_val(i - 8)}, 0);
                return mk(OP_END, SZ_B1, '0, '0, 0);
            end
        endcase
    endfunction

endpackage

// File: rtl/boot_tick_gen.sv
module boot_tick_gen #(
    parameter int CLKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/boot_ms_wait.sv
module boot_ms_wait #(
    parameter int MS_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [MS_W-1:0] len,
    input  logic            tick,
    output logic            expired
);
    logic [MS_W-1:0] ms_cnt;
    logic [MS_W-1:0] target;

    assign expired = (ms_cnt == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_cnt <= '0;
            target <= '0;
        end else if (start) begin
            ms_cnt <= '0;
            target <= len;
        end else if (tick && !expired) begin
            ms_cnt <= ms_cnt + 1'b1;
        end
    end

    // R3
    ms_range_chk: assert property (@(posedge clk) disable iff (rst)
        ms_cnt <= target);

endmodule

// File: rtl/disp_boot_seq.sv
module disp_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int CLKS_PER_MS = 100000,
    parameter int MAX_POLLS   = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_ack,
    input  logic [7:0]  req_rdata,
    output logic        pwr_dn_n,
    output logic        spi_fast,
    output logic        req_valid,
    output logic [1:0]  req_kind,
    output logic [1:0]  req_size,
    output logic [23:0] req_addr,
    output logic [31:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    typedef enum logic [2:0] {S_FETCH, S_REQ, S_WAIT, S_DONE, S_ERR} st_e;

    st_e               state;
    logic [STEP_W-1:0] idx;
    step_t             cur;
    logic [PW-1:0]     poll_cnt;
    logic              tick;
    logic              expired;
    logic              tmr_start;
    logic              is_pd;

    assign cur = boot_step(idx);

    always_comb begin
        is_pd     = (cur.op == OP_PDN_LOW) || (cur.op == OP_PDN_HIGH);
        tmr_start = ((state == S_FETCH) && is_pd) ||
                    ((state == S_REQ) && req_ack && (cur.op == OP_HOST) &&
                     (cur.ms != '0));
    end

    boot_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_start),
        .tick    (tick)
    );

    boot_ms_wait #(.MS_W(MS_W)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .start   (tmr_start),
        .len     (cur.ms),
        .tick    (tick),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_FETCH;
            idx       <= '0;
            poll_cnt  <= '0;
            pwr_dn_n  <= 1'b1;
            spi_fast  <= 1'b0;
            req_valid <= 1'b0;
            req_kind  <= REQ_HOST;
            req_size  <= SZ_B1;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            case (state)
                S_FETCH: begin
                    case (cur.op)
                        OP_PDN_LOW: begin
                            pwr_dn_n <= 1'b0;
                            state    <= S_WAIT;
                        end
                        OP_PDN_HIGH: begin
                            pwr_dn_n <= 1'b1;
                            state    <= S_WAIT;
                        end
                        OP_FAST: begin
                            spi_fast <= 1'b1;
                            idx      <= idx + 1'b1;
                        end
                        OP_END: state <= S_DONE;
                        default: begin
                            req_valid <= 1'b1;
                            req_kind  <= kind_of(cur.op);
                            req_size  <= cur.size;
                            req_addr  <= cur.addr;
                            req_wdata <= cur.data;
                            state     <= S_REQ;
                        end
                    endcase
                end
                S_REQ: begin
                    if (req_ack) begin
                        req_valid <= 1'b0;
                        if (cur.op == OP_POLL) begin
                            if (req_rdata == cur.data[7:0]) begin
                                poll_cnt <= '0;
                                idx      <= idx + 1'b1;
                                state    <= S_FETCH;
                            end else if (poll_cnt == POLL_LAST) begin
                                state <= S_ERR;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                                state    <= S_FETCH;
                            end
                        end else if (cur.ms != '0) begin
                            state <= S_WAIT;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_FETCH;
                        end
                    end
                end
                S_WAIT: begin
                    if (expired) begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done = (state == S_DONE);
    assign err  = (state == S_ERR);
    assign busy = !done && !err;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) &&
            $stable(req_wdata) && $stable(req_kind) && $stable(req_size)));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack) |=> !req_valid);

    // R6
    write_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_WRITE) |-> spi_fast);

    // R6
    read_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_READ) |-> !spi_fast);

    // R2
    pd_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> pwr_dn_n);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !req_valid));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && !req_valid && !spi_fast));

    // R9
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= POLL_LAST);

endmodule

// File: tb/tb_disp_boot_seq.sv
module tb_disp_boot_seq;
    localparam int CPM  = 100;
    localparam int MAXP = 6;
    localparam int LOGN = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_ack = 1'b0;
    logic [7:0]  req_rdata = 8'h00;
    logic        pwr_dn_n, spi_fast, req_valid, busy, done, err;
    logic [1:0]  req_kind, req_size;
    logic [23:0] req_addr;
    logic [31:0] req_wdata;

    disp_boot_seq #(.CLKS_PER_MS(CPM), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst(rst), .req_ack(req_ack), .req_rdata(req_rdata),
        .pwr_dn_n(pwr_dn_n), .spi_fast(spi_fast), .req_valid(req_valid),
        .req_kind(req_kind), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .err(err)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;

    logic [1:0]  l_kind [LOGN];
    logic [1:0]  l_size [LOGN];
    logic [23:0] l_addr [LOGN];
    logic [31:0] l_data [LOGN];
    logic        l_fast [LOGN];
    int          l_rise [LOGN];
    int          l_ack  [LOGN];
    int          n_log = 0;
    int          pd_fall = 0, pd_rise = 0;
    int          mism_left = 0;

    task automatic chk(input bit ok, input string tag, input longint act,
                       input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Responder and monitor: all sampling and driving at the falling edge.
    initial begin
        bit pending = 0;
        int dly = 0;
        logic [1:0] s_kind, s_size;
        logic [23:0] s_addr;
        logic [31:0] s_data;
        bit pd_prev = 1;
        int rise_c = 0;
        void'($urandom(32'd4711));
        forever begin
            @(negedge clk);
            if (rst) begin
                pending = 0;
                req_ack = 1'b0;
                pd_prev = 1;
            end else begin
                if (pd_prev && !pwr_dn_n) pd_fall = cyc;
                if (!pd_prev && pwr_dn_n) pd_rise = cyc;
                pd_prev = pwr_dn_n;
                if (req_ack) begin
                    req_ack = 1'b0;
                end else if (req_valid) begin
                    if (!pending) begin
                        pending = 1;
                        rise_c = cyc;
                        s_kind = req_kind; s_size = req_size;
                        s_addr = req_addr; s_data = req_wdata;
                        dly = int'($urandom % 4);
                    end
                    // R4 fields held while waiting for acknowledge
                    if (s_kind != req_kind || s_size != req_size ||
                        s_addr != req_addr || s_data != req_wdata)
                        chk(0, "R4 request fields changed", longint'(req_addr),
                            longint'(s_addr));
                    if (dly == 0) begin
                        pending = 0;
                        if (n_log < LOGN) begin
                            l_kind[n_log] = req_kind; l_size[n_log] = req_size;
                            l_addr[n_log] = req_addr; l_data[n_log] = req_wdata;
                            l_fast[n_log] = spi_fast; l_rise[n_log] = rise_c;
                            l_ack[n_log]  = cyc;
                        end
                        n_log++;
                        if (req_kind == 2'd1) begin
                            if (mism_left > 0) begin
                                logic [7:0] v;
                                v = 8'($urandom);
                                if (v == 8'h7C) v = 8'h3C;
                                req_rdata = v;
                                mism_left--;
                            end else begin
                                req_rdata = 8'h7C;
                            end
                        end else begin
                            req_rdata = 8'($urandom);
                        end
                        req_ack = 1'b1;
                    end else begin
                        dly--;
                    end
                end
            end
        end
    end

    function automatic logic [7:0] exp_host(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'h44;
            2: return 8'h62;
            default: return 8'h68;
        endcase
    endfunction

    function automatic int exp_ms(input int i);
        case (i)
            0: return 20;
            1: return 10;
            2: return 10;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] exp_tv(input int k);
        case (k)
            0: return 16'd548; 1: return 16'd43;  2: return 16'd480;
            3: return 16'd0;   4: return 16'd41;  5: return 16'd292;
            6: return 16'd12;  7: return 16'd272; 8: return 16'd0;
            default: return 16'd10;
        endcase
    endfunction

    // Expected write list: {size, addr, data}
    task automatic exp_wr(input int i, output logic [1:0] sz,
                          output logic [23:0] a, output logic [31:0] d);
        if (i < 10) begin
            sz = 2'd1; a = 24'h302000 + 24'(4 * i); d = {16'h0, exp_tv(i)};
        end else begin
            case (i)
                10: begin sz = 2'd0; a = 24'h302028; d = 32'd0; end
                11: begin sz = 2'd0; a = 24'h30202C; d = 32'd1; end
                12: begin sz = 2'd0; a = 24'h302030; d = 32'd1; end
                13: begin sz = 2'd2; a = 24'h300000; d = 32'h26000007; end
                14: begin sz = 2'd2; a = 24'h300004; d = 32'h0; end
                15: begin sz = 2'd0; a = 24'h302038; d = 32'd1; end
                default: begin sz = 2'd0; a = 24'h302034; d = 32'd5; end
            endcase
        end
    endtask

    task automatic run_case(input int k_bad);
        bit expect_err;
        int n_reads, t0, n_end;
        expect_err = (k_bad >= MAXP);
        n_reads = expect_err ? MAXP : k_bad + 1;
        @(negedge clk);
        rst = 1'b1;
        mism_left = k_bad;
        repeat (4) @(negedge clk);
        n_log = 0;
        // R1 reset state
        chk(pwr_dn_n == 1'b1 && spi_fast == 1'b0 && req_valid == 1'b0 &&
            done == 1'b0 && err == 1'b0, "R1 reset outputs",
            longint'({pwr_dn_n, spi_fast, req_valid, done, err}), 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0 && err == 1'b0 && req_valid == 1'b0,
            "R1 busy after reset", longint'({busy, done, err}), 3'b100);
        t0 = cyc;
        while (!done && !err && (cyc - t0) < 30000) @(negedge clk);
        n_end = n_log;
        repeat (60) @(negedge clk);
        if (expect_err) begin
            chk(err == 1'b1 && done == 1'b0 && busy == 1'b0, "R9 error flags",
                longint'({busy, done, err}), 3'b001);
            chk(n_log == 4 + MAXP, "R9 request count at limit", n_log, 4 + MAXP);
            chk(spi_fast == 1'b0, "R9 fast select stays low", spi_fast, 0);
        end else begin
            chk(done == 1'b1 && err == 1'b0 && busy == 1'b0, "R10 done flags",
                longint'({busy, done, err}), 3'b010);
            chk(n_log == 4 + n_reads + 17, "R10 total requests", n_log,
                4 + n_reads + 17);
        end
        chk(n_log == n_end, "R10 R9 no request after end", n_log, n_end);
        if (n_log > LOGN) return;

        // R2 power-down pulse
        chk(pd_rise - pd_fall >= 20 * CPM && pd_rise - pd_fall <= 20 * CPM + 6,
            "R2 power-down low time", pd_rise - pd_fall, 20 * CPM);
        chk(n_log > 0 && l_rise[0] - pd_rise >= 20 * CPM,
            "R2 high time before first request", l_rise[0] - pd_rise, 20 * CPM);

        // R3 host commands and waits
        for (int i = 0; i < 4; i++) begin
            chk(l_kind[i] == 2'd0 && l_size[i] == 2'd0, "R3 host kind/size",
                longint'({l_kind[i], l_size[i]}), 0);
            chk(l_data[i][7:0] == exp_host(i), "R3 host command byte",
                longint'(l_data[i][7:0]), longint'(exp_host(i)));
            if (exp_ms(i) > 0) begin
                int g;
                g = l_rise[i + 1] - l_ack[i];
                chk(g >= exp_ms(i) * CPM && g <= exp_ms(i) * CPM + 6,
                    "R3 wait after host command", g, exp_ms(i) * CPM);
            end else begin
                chk(l_rise[i + 1] - l_ack[i] <= 8, "R3 no wait after core reset",
                    l_rise[i + 1] - l_ack[i], 0);
            end
        end

        // R5 R6 identification reads
        for (int i = 0; i < n_reads; i++) begin
            int j;
            j = 4 + i;
            chk(l_kind[j] == 2'd1 && l_size[j] == 2'd0 && l_addr[j] == 24'h302040,
                "R5 identification read", longint'(l_addr[j]), 24'h302040);
            chk(l_fast[j] == 1'b0, "R6 slow clock during poll", l_fast[j], 0);
        end

        // R7 R8 R6 write list
        if (!expect_err) begin
            for (int i = 0; i < 17; i++) begin
                int j;
                logic [1:0] sz;
                logic [23:0] a;
                logic [31:0] d;
                j = 4 + n_reads + i;
                exp_wr(i, sz, a, d);
                chk(l_kind[j] == 2'd2 && l_size[j] == sz,
                    (i < 13) ? "R7 write kind/size" : "R8 write kind/size",
                    longint'({l_kind[j], l_size[j]}), longint'({2'd2, sz}));
                chk(l_addr[j] == a, (i < 13) ? "R7 write address" : "R8 write address",
                    longint'(l_addr[j]), longint'(a));
                chk(l_data[j] == d, (i < 13) ? "R7 write data" : "R8 write data",
                    longint'(l_data[j]), longint'(d));
                chk(l_fast[j] == 1'b1, "R6 fast clock during writes", l_fast[j], 1);
            end
        end
    endtask

    initial begin
        int k_rand;
        run_case(0);
        run_case(3);
        run_case(MAXP - 1);
        k_rand = int'($urandom % MAXP);
        run_case(k_rand);
        run_case(MAXP + 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(10 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule